// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block gives the fetch stage a predicted next program counter before the instruction at the current fetch address has been decoded. It holds a direct-mapped table of taken control transfers. Each slot stores a valid flag, the complete address of the branch that owns it, and the address that branch last jumped to. The fetch address picks a slot through its word-index bits. If that slot is valid and its stored address equals the whole fetch address, the stored destination becomes the next fetch address. Otherwise fetch falls through to the sequential address, fetch address plus 4.

Training happens only when a branch or jump resolves in the execute stage. The pipeline reports the branch address, the resolved direction, the resolved destination, and the next address that fetch actually used after that branch. The block then does one of three things. It fills a slot for a taken branch that missed. It rewrites a slot whose stored destination was wrong. It drops a slot whose branch resolved not-taken. In the same cycle, from the same report, it raises a misprediction flag together with the address fetch must restart from. Non-control instructions never present a report, so they never change the table.

Top module: `btb_predictor`

## Requirements
- R1: While reset is asserted, every slot becomes invalid. After reset, every fetch address produces `predHit` = 0 and `predNextPc` = `fetchPc` + 4.
- R2: A fetch address whose slot is valid and holds that exact address produces `predHit` = 1 and `predNextPc` = the stored destination, combinationally.
- R3: A fetch address whose slot is invalid, or holds a different address, produces `predHit` = 0 and `predNextPc` = `fetchPc` + 4.
- R4: A valid taken report for an address that is not in the table writes the address and its destination into slot `rslvPc[IDX_W+1:2]` at the next rising edge. From then on, that address hits.
- R5: A valid taken report for an address that hits with a different stored destination replaces the destination at the next edge.
- R6: A valid not-taken report for an address that hits invalidates its slot at the next edge.
- R7: `mispredict` is high in the same cycle as a valid report exactly when `rslvPredNext` differs from the correct next address. That address is `rslvTarget` if taken and `rslvPc` + 4 if not. `redirectPc` carries the correct next address.
- R8: While `rslvValid` is low, the table does not change and `mispredict` stays low, whatever the other report inputs carry.
- R9: Two addresses that are equal modulo 4·2^IDX_W share a slot. A taken report for one evicts the other, which then falls through to fetch address plus 4.
- R10: A not-taken report for an address whose slot is owned by a different address leaves that other entry valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetchPc | input | PC_W | Current fetch address |
| predNextPc | output | PC_W | Predicted next fetch address |
| predHit | output | 1 | Fetch address found valid in the table |
| rslvValid | input | 1 | A control instruction resolved this cycle |
| rslvPc | input | PC_W | Address of the resolved branch |
| rslvTaken | input | 1 | Resolved direction, 1 = taken |
| rslvTarget | input | PC_W | Resolved destination address |
| rslvPredNext | input | PC_W | Next address that fetch used after this branch |
| mispredict | output | 1 | The fetched path after the branch was wrong |
| redirectPc | output | PC_W | Correct next address after the resolved branch |

## Verification
The bench targets aliasing pairs that differ by exactly the table span. Indexing on byte bits instead of word bits, or comparing only the index bits, would make the wrong member of a pair hit, or let a not-taken report for one member delete the other's entry. It checks that a wrong stored destination is replaced rather than kept. A design that writes only on a miss would keep predicting the stale destination. It checks that a not-taken report invalidates the slot, and that a report with the valid strobe low changes nothing. A design that ignored the strobe would retrain from garbage and flag phantom mispredictions. A second reset after training checks that every valid flag is cleared.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // strobes from the resolve control to the table datapath
  typedef struct packed {
    logic wrEn;   // fill or rewrite the addressed slot
    logic clrEn;  // drop the addressed slot
  } ctlStrobes_t;
endpackage

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetchPc,
  output logic            fetchHit,
  output logic [PC_W-1:0] fetchNext,
  input  logic [PC_W-1:0] lookPc,
  output logic            lookHit,
  output logic [PC_W-1:0] lookTgt,
  input  ctlStrobes_t     ctl,
  input  logic [PC_W-1:0] wrTgt
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] validQ;
  logic [PC_W-1:0]  tagQ [DEPTH];
  logic [PC_W-1:0]  tgtQ [DEPTH];

  logic [IDX_W-1:0] fIdx;
  logic [IDX_W-1:0] lIdx;

  assign fIdx = fetchPc[IDX_W+1:2];
  assign lIdx = lookPc[IDX_W+1:2];

  // fetch-side lookup: full address compare
  always_comb begin
    fetchHit  = validQ[fIdx] && (tagQ[fIdx] == fetchPc);
    fetchNext = fetchHit ? tgtQ[fIdx] : fetchPc + PC_W'(4);
  end

  // resolve-side lookup
  always_comb begin
    lookHit = validQ[lIdx] && (tagQ[lIdx] == lookPc);
    lookTgt = tgtQ[lIdx];
  end

  // valid flags: cleared by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
    end else if (ctl.wrEn) begin
      validQ[lIdx] <= 1'b1;
    end else if (ctl.clrEn) begin
      validQ[lIdx] <= 1'b0;
    end
  end

  // tag and destination storage: no reset needed
  always_ff @(posedge clk) begin
    if (!rst && ctl.wrEn) begin
      tagQ[lIdx] <= lookPc;
      tgtQ[lIdx] <= wrTgt;
    end
  end
endmodule

// File: rtl/btb_resolve_ctl.sv
module btb_resolve_ctl
  import btb_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            rslvValid,
  input  logic [PC_W-1:0] rslvPc,
  input  logic            rslvTaken,
  input  logic [PC_W-1:0] rslvTarget,
  input  logic [PC_W-1:0] rslvPredNext,
  input  logic            lookHit,
  input  logic [PC_W-1:0] lookTgt,
  output ctlStrobes_t     ctl,
  output logic            mispredict,
  output logic [PC_W-1:0] redirectPc
);
  logic [PC_W-1:0] correctNext;

  always_comb begin
    correctNext = rslvTaken ? rslvTarget : rslvPc + PC_W'(4);
    redirectPc  = correctNext;
    mispredict  = rslvValid && (correctNext != rslvPredNext);
    // write only when the table would otherwise be wrong next time
    ctl.wrEn  = rslvValid && rslvTaken && (!lookHit || (lookTgt != rslvTarget));
    // drop only a slot that this very branch owns
    ctl.clrEn = rslvValid && !rslvTaken && lookHit;
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetchPc,
  output logic [PC_W-1:0] predNextPc,
  output logic            predHit,
  input  logic            rslvValid,
  input  logic [PC_W-1:0] rslvPc,
  input  logic            rslvTaken,
  input  logic [PC_W-1:0] rslvTarget,
  input  logic [PC_W-1:0] rslvPredNext,
  output logic            mispredict,
  output logic [PC_W-1:0] redirectPc
);
  ctlStrobes_t     ctl;
  logic            lookHit;
  logic [PC_W-1:0] lookTgt;

  btb_store #(.PC_W(PC_W), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .fetchPc  (fetchPc),
    .fetchHit (predHit),
    .fetchNext(predNextPc),
    .lookPc   (rslvPc),
    .lookHit  (lookHit),
    .lookTgt  (lookTgt),
    .ctl      (ctl),
    .wrTgt    (rslvTarget)
  );

  btb_resolve_ctl #(.PC_W(PC_W)) u_ctl (
    .rslvValid   (rslvValid),
    .rslvPc      (rslvPc),
    .rslvTaken   (rslvTaken),
    .rslvTarget  (rslvTarget),
    .rslvPredNext(rslvPredNext),
    .lookHit     (lookHit),
    .lookTgt     (lookTgt),
    .ctl         (ctl),
    .mispredict  (mispredict),
    .redirectPc  (redirectPc)
  );
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] fetchPc,
  input logic [PC_W-1:0] predNextPc,
  input logic            predHit,
  input logic            rslvValid,
  input logic [PC_W-1:0] rslvPc,
  input logic            rslvTaken,
  input logic [PC_W-1:0] rslvTarget,
  input logic [PC_W-1:0] rslvPredNext,
  input logic            mispredict,
  input logic [PC_W-1:0] redirectPc
);
  // R1: first cycle out of reset, nothing is valid
  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !predHit);

  // R4: a taken report is visible to fetch on the next cycle
  a_r4_fill_visible: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rslvValid) && $past(rslvTaken) && fetchPc == $past(rslvPc))
      |-> (predHit && predNextPc == $past(rslvTarget)));

  // R6: a not-taken report leaves its own address falling through
  a_r6_drop_visible: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rslvValid) && !$past(rslvTaken) && fetchPc == $past(rslvPc))
      |-> (!predHit && predNextPc == fetchPc + PC_W'(4)));

  // R7: a flagged redirect never points where fetch already went
  a_r7_redirect_differs: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> (redirectPc != rslvPredNext));

  // R8: no report, no misprediction
  a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !rslvValid |-> !mispredict);

  // R3: a miss always falls through sequentially
  a_r3_miss_sequential: assert property (@(posedge clk) disable iff (rst)
    !predHit |-> (predNextPc == fetchPc + PC_W'(4)));
endmodule

bind btb_predictor btb_checker #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .fetchPc(fetchPc), .predNextPc(predNextPc),
  .predHit(predHit), .rslvValid(rslvValid), .rslvPc(rslvPc),
  .rslvTaken(rslvTaken), .rslvTarget(rslvTarget),
  .rslvPredNext(rslvPredNext), .mispredict(mispredict),
  .redirectPc(redirectPc)
);

// File: tb/sim_btb_predictor.sv
module sim_btb_predictor;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] fetchPc = '0;
  logic [PC_W-1:0] predNextPc;
  logic            predHit;
  logic            rslvValid = 1'b0;
  logic [PC_W-1:0] rslvPc = '0;
  logic            rslvTaken = 1'b0;
  logic [PC_W-1:0] rslvTarget = '0;
  logic [PC_W-1:0] rslvPredNext = '0;
  logic            mispredict;
  logic [PC_W-1:0] redirectPc;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  btb_predictor #(.PC_W(PC_W), .IDX_W(7)) u0 (
    .clk(clk), .rst(rst), .fetchPc(fetchPc), .predNextPc(predNextPc),
    .predHit(predHit), .rslvValid(rslvValid), .rslvPc(rslvPc),
    .rslvTaken(rslvTaken), .rslvTarget(rslvTarget),
    .rslvPredNext(rslvPredNext), .mispredict(mispredict),
    .redirectPc(redirectPc)
  );

  task automatic chk(input string req, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // fetch-side probe; comb outputs sampled 1 ns after driving
  task automatic probe(input string req, input logic [PC_W-1:0] pc,
                       input logic hitExp, input logic [PC_W-1:0] nextExp);
    fetchPc = pc;
    #1;
    chk(req, {31'd0, predHit}, {31'd0, hitExp});
    chk(req, predNextPc, nextExp);
  endtask

  // present a report, check comb outputs, then apply it at one edge
  task automatic report(input string req, input logic v, input logic [PC_W-1:0] pc,
                        input logic tk, input logic [PC_W-1:0] tgt,
                        input logic [PC_W-1:0] pn, input logic misExp,
                        input logic [PC_W-1:0] redirExp);
    rslvValid = v; rslvPc = pc; rslvTaken = tk; rslvTarget = tgt; rslvPredNext = pn;
    #1;
    chk(req, {31'd0, mispredict}, {31'd0, misExp});
    if (misExp) chk(req, redirectPc, redirExp);
    step();
    rslvValid = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    #1;
  endtask

  task automatic tReset();
    probe("R1 after reset", 32'h100, 1'b0, 32'h104);
    probe("R1 after reset", 32'h404, 1'b0, 32'h408);
  endtask

  task automatic tAllocate();
    report("R7 taken miss", 1'b1, 32'h404, 1'b1, 32'h800, 32'h408, 1'b1, 32'h800);
    probe("R4 filled", 32'h404, 1'b1, 32'h800);
    probe("R2 hit target", 32'h404, 1'b1, 32'h800);
  endtask

  task automatic tAlias();
    // 0x604 shares slot 1 with 0x404 (differ by 4*128)
    probe("R3 alias no hit", 32'h604, 1'b0, 32'h608);
    report("R7 not-taken correct", 1'b1, 32'h604, 1'b0, 32'h0, 32'h608, 1'b0, 32'h0);
    probe("R10 other owner kept", 32'h404, 1'b1, 32'h800);
  endtask

  task automatic tCorrect();
    report("R5 wrong target", 1'b1, 32'h404, 1'b1, 32'h900, 32'h800, 1'b1, 32'h900);
    probe("R5 target replaced", 32'h404, 1'b1, 32'h900);
    report("R7 correct predict", 1'b1, 32'h404, 1'b1, 32'h900, 32'h900, 1'b0, 32'h0);
  endtask

  task automatic tIdle();
    report("R8 idle no flag", 1'b0, 32'h404, 1'b0, 32'hAA0, 32'h123, 1'b0, 32'h0);
    probe("R8 idle no change", 32'h404, 1'b1, 32'h900);
  endtask

  task automatic tEvict();
    report("R9 alias fill", 1'b1, 32'h604, 1'b1, 32'hC00, 32'h608, 1'b1, 32'hC00);
    probe("R9 new owner", 32'h604, 1'b1, 32'hC00);
    probe("R9 evicted", 32'h404, 1'b0, 32'h408);
  endtask

  task automatic tInvalidate();
    report("R7 predicted taken went not-taken", 1'b1, 32'h604, 1'b0, 32'h0, 32'hC00, 1'b1, 32'h608);
    probe("R6 dropped", 32'h604, 1'b0, 32'h608);
  endtask

  task automatic tNeighbours();
    report("R4 fill a", 1'b1, 32'h10, 1'b1, 32'h2000, 32'h14, 1'b1, 32'h2000);
    report("R4 fill b", 1'b1, 32'h14, 1'b1, 32'h3000, 32'h18, 1'b1, 32'h3000);
    probe("R2 slot a", 32'h10, 1'b1, 32'h2000);
    probe("R2 slot b", 32'h14, 1'b1, 32'h3000);
  endtask

  task automatic tReReset();
    doReset();
    probe("R1 cleared a", 32'h10, 1'b0, 32'h14);
    probe("R1 cleared b", 32'h14, 1'b0, 32'h18);
  endtask

  initial begin
    @(negedge clk);
    doReset();
    tReset();
    tAllocate();
    tAlias();
    tCorrect();
    tIdle();
    tEvict();
    tInvalidate();
    tNeighbours();
    tReReset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule